// File: doc/BRIEF.md
# Active-Mode Pass-Through Transfer Sequencer

This block is the bridge-side engine for pass-through transfers when the bridge owns the add-on bus. It takes a queued request, then drives the add-on bus itself. The request carries a 32-bit target address, byte enables, a burst length and a direction. The block first places the address on the shared address/data bus for one cycle, marking it with a low-active address-valid strobe. It then runs the data beats. For a write from the host side, the block drives the words out. For a read, the add-on logic supplies the words and the block captures them.

A width pin chooses between a 32-bit and a 16-bit data path. In 16-bit mode each word is split into two half-word beats. The add-on side can stretch any beat by holding its wait input high. Every beat that completes is marked by a low-active transfer-complete strobe. When the mode pin is high (passive), the block refuses new requests and leaves the bus alone.

Top module: `pt_active_seq`

## Requirements
- R1: `req_ready` is high exactly when the sequencer is idle and `passive_mode` is low. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high.
- R2: While idle, `ab_addr_n` and `ab_xfer_n` are high, `ab_dq_oe` is low, `ab_be_n` is 4'hF and `wdata_pop` is low. While `passive_mode` is high, no request is accepted, however long `req_valid` stays high.
- R3: In the cycle after acceptance, `ab_addr_n` is low for exactly one cycle. In that cycle `ab_dq_oe` is high and `ab_dq_out` carries all 32 bits of the request address, whatever the width setting.
- R4: The address cycle is followed by (req_len+1) data words. A word is one beat in 32-bit mode (`wide_bus`=1) and two beats in 16-bit mode (`wide_bus`=0). After the last beat the sequencer returns to idle. `ab_addr_n` stays high during data beats.
- R5: During a data beat, `ab_xfer_n` equals `ab_wait`. A beat with `ab_wait` high is held and repeated unchanged in the next cycle. A beat completes only in a cycle where `ab_wait` is low.
- R6: In a 16-bit write, the low half of the word goes out first on `ab_dq_out[15:0]`, then the high half. `ab_dq_out[31:16]` is driven to zero. `ab_be_n[1:0]` carries the inverted enables of the active half (`req_be[1:0]`, then `req_be[3:2]`), and `ab_be_n[3:2]` is 2'b11.
- R7: In a 32-bit write, `ab_dq_out` carries the whole current `wdata` word and `ab_be_n` equals the inverted `req_be`.
- R8: During read beats `ab_dq_oe` is low. One cycle after the final beat of each read word, `rd_valid` pulses for one cycle. `rd_data` then holds `ab_dq_in` from that beat (32-bit mode), or {second beat `ab_dq_in[15:0]`, first beat `ab_dq_in[15:0]`} (16-bit mode).
- R9: `wdata_pop` is high in exactly the cycle in which the final beat of a write word completes. This tells the upstream queue to present the next word.
- R10: Width, direction, byte enables, address and length are captured at acceptance. Changes on `wide_bus` or the request inputs during a transfer have no effect on it.
- R11: Under reset, the block shows the idle outputs of R2, and `rd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Add-on clock |
| rst_n | input | 1 | Synchronous active-low reset |
| passive_mode | input | 1 | High: passive, block does not start transfers; low: active |
| wide_bus | input | 1 | 1 = 32-bit data path, 0 = 16-bit data path |
| req_valid | input | 1 | Queued request present |
| req_ready | output | 1 | Request accepted on this edge if valid |
| req_addr | input | 32 | Pass-through address |
| req_dir | input | 1 | 1 = drive data to add-on (host write), 0 = capture from add-on (host read) |
| req_be | input | 4 | Active-high byte enables |
| req_len | input | LEN_W | Number of words minus one |
| wdata | input | 32 | Current write word from the upstream queue |
| wdata_pop | output | 1 | Current write word fully sent |
| ab_wait | input | 1 | Add-on wait; high holds the current beat |
| ab_dq_in | input | 32 | Add-on bus value seen on read beats |
| ab_dq_out | output | 32 | Value driven onto the add-on bus |
| ab_dq_oe | output | 1 | Bus driver enable |
| ab_addr_n | output | 1 | Low: address present on bus |
| ab_xfer_n | output | 1 | Low: a data beat completes this cycle |
| ab_be_n | output | 4 | Low-active lane enables for the current beat |
| rd_data | output | 32 | Assembled read word |
| rd_valid | output | 1 | Read word valid pulse |

## Verification
All bus outputs are combinational from the state and the current `ab_wait`. `ab_addr_n` falls in the first cycle after the accepting edge. Each beat's `ab_xfer_n` and `wdata_pop` are therefore due in the same cycle as the wait sample that completes it. `rd_valid` and `rd_data` come one cycle after the completing beat. The bench drives inputs on the falling edge and compares a quarter period later. Its queue-based reference model advances once per cycle from the same input values, so each expectation lands in the cycle where the design's output is due.

// File: rtl/pt_pkg.sv
// Shared types for the active-mode pass-through sequencer.
package pt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2
    } pt_state_e;
endpackage

// File: rtl/pt_seq_ctrl.sv
// Sequencer control: accepts a request, walks idle -> address -> data beats -> idle.
// Assumes: the request fields are stable while req_valid is high; ab_wait is synchronous to clk.
module pt_seq_ctrl
    import pt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LEN_W  = 8,
    localparam int BE_W  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              passive_mode,
    input  logic              wide_bus,
    input  logic              req_valid,
    input  logic [DATA_W-1:0] req_addr,
    input  logic              req_dir,
    input  logic [BE_W-1:0]   req_be,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              ab_wait,
    output logic              req_ready,
    output pt_state_e         state,
    output logic              beat_done,
    output logic              word_done,
    output logic              half_sel,
    output logic              wide_q,
    output logic              dir_q,
    output logic [BE_W-1:0]   be_q,
    output logic [DATA_W-1:0] addr_q
);
    logic [LEN_W-1:0] words_left;

    // Accept only from idle in active mode.
    always_comb req_ready = (state == ST_IDLE) && !passive_mode;

    // A beat finishes in any data cycle without wait; a word after its last beat.
    always_comb begin
        beat_done = (state == ST_DATA) && !ab_wait;
        word_done = beat_done && (wide_q || half_sel);
    end

    // State, request capture, half and word counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            half_sel   <= 1'b0;
            wide_q     <= 1'b1;
            dir_q      <= 1'b0;
            be_q       <= '0;
            addr_q     <= '0;
            words_left <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req_valid && req_ready) begin
                        state      <= ST_ADDR;
                        half_sel   <= 1'b0;
                        wide_q     <= wide_bus;
                        dir_q      <= req_dir;
                        be_q       <= req_be;
                        addr_q     <= req_addr;
                        words_left <= req_len;
                    end
                end
                ST_ADDR: state <= ST_DATA;
                ST_DATA: begin
                    if (beat_done && !wide_q) half_sel <= ~half_sel;
                    if (word_done) begin
                        if (words_left == '0) state <= ST_IDLE;
                        else words_left <= words_left - 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pt_lane_steer.sv
// Bus steering: chooses what goes onto the add-on bus and which lanes are enabled.
// Assumes: in 16-bit mode the active half always travels on the low lanes.
module pt_lane_steer
    import pt_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int BE_W   = DATA_W / 8,
    localparam int HALF_W = DATA_W / 2,
    localparam int HBE    = BE_W / 2
) (
    input  pt_state_e         state,
    input  logic [DATA_W-1:0] addr_q,
    input  logic [DATA_W-1:0] wdata,
    input  logic              half_sel,
    input  logic              wide_q,
    input  logic              dir_q,
    input  logic [BE_W-1:0]   be_q,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic [BE_W-1:0]   be_n,
    output logic              addr_n
);
    logic [HALF_W-1:0] half_word;
    logic [HBE-1:0]    half_be;

    // Pick the active half of the word and of its enables.
    always_comb begin
        half_word = half_sel ? wdata[DATA_W-1:HALF_W] : wdata[HALF_W-1:0];
        half_be   = half_sel ? be_q[BE_W-1:HBE]       : be_q[HBE-1:0];
    end

    // Drive address in the address cycle, write data in write beats, nothing otherwise.
    always_comb begin
        dq_out = '0;
        dq_oe  = 1'b0;
        be_n   = '1;
        addr_n = 1'b1;
        unique case (state)
            ST_ADDR: begin
                addr_n = 1'b0;
                dq_oe  = 1'b1;
                dq_out = addr_q;
            end
            ST_DATA: begin
                be_n = wide_q ? ~be_q : {{HBE{1'b1}}, ~half_be};
                if (dir_q) begin
                    dq_oe  = 1'b1;
                    dq_out = wide_q ? wdata : {{HALF_W{1'b0}}, half_word};
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pt_rd_pack.sv
// Read packer: collects read beats into words and presents each word for one cycle.
// Assumes: beat_done marks a completed beat; half_sel is the half of that beat.
module pt_rd_pack #(
    parameter int DATA_W = 32,
    localparam int HALF_W = DATA_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              beat_done,
    input  logic              dir_q,
    input  logic              wide_q,
    input  logic              half_sel,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    logic [HALF_W-1:0] lo_half;

    // Capture read beats; emit a word after its last beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
            lo_half  <= '0;
        end else begin
            rd_valid <= 1'b0;
            if (beat_done && !dir_q) begin
                if (wide_q) begin
                    rd_data  <= dq_in;
                    rd_valid <= 1'b1;
                end else if (!half_sel) begin
                    lo_half <= dq_in[HALF_W-1:0];
                end else begin
                    rd_data  <= {dq_in[HALF_W-1:0], lo_half};
                    rd_valid <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/pt_active_seq.sv
// Top: active-mode pass-through sequencer for the add-on bus.
// Assumes: upstream holds wdata until wdata_pop; add-on logic drives ab_dq_in on read beats.
module pt_active_seq
    import pt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LEN_W  = 8,
    localparam int BE_W  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              passive_mode,
    input  logic              wide_bus,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [DATA_W-1:0] req_addr,
    input  logic              req_dir,
    input  logic [BE_W-1:0]   req_be,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [DATA_W-1:0] wdata,
    output logic              wdata_pop,
    input  logic              ab_wait,
    input  logic [DATA_W-1:0] ab_dq_in,
    output logic [DATA_W-1:0] ab_dq_out,
    output logic              ab_dq_oe,
    output logic              ab_addr_n,
    output logic              ab_xfer_n,
    output logic [BE_W-1:0]   ab_be_n,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    pt_state_e         state;
    logic              beat_done, word_done, half_sel, wide_q, dir_q;
    logic [BE_W-1:0]   be_q;
    logic [DATA_W-1:0] addr_q;

    pt_seq_ctrl #(.DATA_W(DATA_W), .LEN_W(LEN_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .passive_mode(passive_mode), .wide_bus(wide_bus),
        .req_valid(req_valid), .req_addr(req_addr), .req_dir(req_dir), .req_be(req_be),
        .req_len(req_len), .ab_wait(ab_wait), .req_ready(req_ready), .state(state),
        .beat_done(beat_done), .word_done(word_done), .half_sel(half_sel),
        .wide_q(wide_q), .dir_q(dir_q), .be_q(be_q), .addr_q(addr_q)
    );

    pt_lane_steer #(.DATA_W(DATA_W)) steer_i (
        .state(state), .addr_q(addr_q), .wdata(wdata), .half_sel(half_sel),
        .wide_q(wide_q), .dir_q(dir_q), .be_q(be_q), .dq_out(ab_dq_out),
        .dq_oe(ab_dq_oe), .be_n(ab_be_n), .addr_n(ab_addr_n)
    );

    pt_rd_pack #(.DATA_W(DATA_W)) pack_i (
        .clk(clk), .rst_n(rst_n), .beat_done(beat_done), .dir_q(dir_q),
        .wide_q(wide_q), .half_sel(half_sel), .dq_in(ab_dq_in),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    // Per-beat completion strobe and write-word release.
    always_comb begin
        ab_xfer_n = ~beat_done;
        wdata_pop = word_done && dir_q;
    end
endmodule

// File: rtl/pt_active_seq_chk.sv
// Port-level protocol checker for pt_active_seq, attached by bind.
module pt_active_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic passive_mode,
    input logic req_ready,
    input logic ab_wait,
    input logic ab_addr_n,
    input logic ab_xfer_n,
    input logic ab_dq_oe,
    input logic wdata_pop,
    input logic rd_valid
);
    // R1 / R2: never ready while passive.
    p_no_ready_passive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        passive_mode |-> !req_ready);

    // R3: address strobe lasts one cycle and the bus is driven with it.
    p_addr_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ab_addr_n |=> ab_addr_n);
    p_addr_driven_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ab_addr_n |-> ab_dq_oe);

    // R4: no beat completes during the address cycle.
    p_addr_no_xfer_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ab_addr_n |-> ab_xfer_n);

    // R5: a waited cycle never completes a beat.
    p_wait_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ab_wait |-> ab_xfer_n);

    // R9: a word is released only on a completing driven beat.
    p_pop_on_xfer_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wdata_pop |-> (!ab_xfer_n && ab_dq_oe));

    // R8: read word follows a completed undriven beat.
    p_rd_after_beat_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(!ab_xfer_n) && !$past(ab_dq_oe)));

    // R1: ready only while no address or beat activity.
    p_ready_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (ab_addr_n && ab_xfer_n && !ab_dq_oe));
endmodule

bind pt_active_seq pt_active_seq_chk chk_i (
    .clk(clk), .rst_n(rst_n), .passive_mode(passive_mode), .req_ready(req_ready),
    .ab_wait(ab_wait), .ab_addr_n(ab_addr_n), .ab_xfer_n(ab_xfer_n),
    .ab_dq_oe(ab_dq_oe), .wdata_pop(wdata_pop), .rd_valid(rd_valid)
);

// File: tb/pt_active_seq_tb_top.sv
// Bench: queue-based reference model compared against the sequencer on every clock.
module pt_active_seq_tb_top;
    localparam int CLK_P = 10;
    localparam int LEN_W = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        passive_mode = 1'b0, wide_bus = 1'b1, req_valid = 1'b0, req_dir = 1'b0;
    logic [31:0] req_addr = '0, wdata = '0, ab_dq_in = '0;
    logic [3:0]  req_be = '0;
    logic [LEN_W-1:0] req_len = '0;
    logic        ab_wait = 1'b0;
    logic        req_ready, wdata_pop, ab_dq_oe, ab_addr_n, ab_xfer_n, rd_valid;
    logic [31:0] ab_dq_out, rd_data;
    logic [3:0]  ab_be_n;

    pt_active_seq #(.DATA_W(32), .LEN_W(LEN_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .passive_mode(passive_mode), .wide_bus(wide_bus),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_dir(req_dir), .req_be(req_be), .req_len(req_len), .wdata(wdata),
        .wdata_pop(wdata_pop), .ab_wait(ab_wait), .ab_dq_in(ab_dq_in),
        .ab_dq_out(ab_dq_out), .ab_dq_oe(ab_dq_oe), .ab_addr_n(ab_addr_n),
        .ab_xfer_n(ab_xfer_n), .ab_be_n(ab_be_n), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    always #(CLK_P/2) clk = ~clk;

    typedef struct {
        bit       wide;
        bit       dir;
        bit       hi;
        bit       eow;
        logic [3:0] be;
    } beat_t;

    beat_t       bq[$];
    logic [31:0] wq[$];
    int          phase = 0;
    logic [31:0] m_addr = '0, exp_rd = '0;
    logic [15:0] m_lo = '0;
    bit          exp_rv = 0, acc_evt = 0, wait_rand = 0, done = 0;
    int          wait_pct = 0, n_chk = 0, n_bad = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model: drives bus-side inputs, compares, then advances one cycle.
    initial begin
        forever begin
            beat_t b;
            bit    exp_ready;
            @(negedge clk);
            ab_wait  = wait_rand ? (($urandom % 100) < wait_pct) : 1'b0;
            ab_dq_in = $urandom;
            wdata    = (wq.size() != 0) ? wq[0] : 32'hDEAD_BEEF;
            #(CLK_P/4);
            acc_evt = 0;
            if (!rst_n) begin
                chk("R11 addr_n", {31'd0, ab_addr_n}, 32'd1);
                chk("R11 xfer_n", {31'd0, ab_xfer_n}, 32'd1);
                chk("R11 oe", {31'd0, ab_dq_oe}, 32'd0);
                chk("R11 rd_valid", {31'd0, rd_valid}, 32'd0);
                continue;
            end
            exp_ready = (phase == 0) && !passive_mode;
            chk("R1 req_ready", {31'd0, req_ready}, {31'd0, exp_ready});
            chk("R8 rd_valid", {31'd0, rd_valid}, {31'd0, exp_rv});
            if (exp_rv) chk("R8 rd_data", rd_data, exp_rd);
            if (phase == 0) begin
                chk("R2 addr_n", {31'd0, ab_addr_n}, 32'd1);
                chk("R2 xfer_n", {31'd0, ab_xfer_n}, 32'd1);
                chk("R2 oe", {31'd0, ab_dq_oe}, 32'd0);
                chk("R2 be_n", {28'd0, ab_be_n}, 32'hF);
                chk("R2 pop", {31'd0, wdata_pop}, 32'd0);
            end else if (phase == 1) begin
                chk("R3 addr_n", {31'd0, ab_addr_n}, 32'd0);
                chk("R3 oe", {31'd0, ab_dq_oe}, 32'd1);
                chk("R3 addr", ab_dq_out, m_addr);
                chk("R3 xfer_n", {31'd0, ab_xfer_n}, 32'd1);
            end else begin
                b = bq[0];
                chk("R4 addr_n", {31'd0, ab_addr_n}, 32'd1);
                chk("R5 xfer_n", {31'd0, ab_xfer_n}, {31'd0, ab_wait});
                chk("R8 oe", {31'd0, ab_dq_oe}, {31'd0, b.dir});
                if (b.wide) chk("R7 be_n", {28'd0, ab_be_n}, {28'd0, ~b.be});
                else chk("R6 be_n", {28'd0, ab_be_n},
                         {28'd0, 2'b11, ~(b.hi ? b.be[3:2] : b.be[1:0])});
                if (b.dir) begin
                    if (b.wide) chk("R7 data", ab_dq_out, wq[0]);
                    else chk("R6 data", ab_dq_out, {16'd0, b.hi ? wq[0][31:16] : wq[0][15:0]});
                end
                chk("R9 pop", {31'd0, wdata_pop}, {31'd0, (b.dir && !ab_wait && b.eow)});
            end
            // advance the model
            exp_rv = 0;
            if (phase == 0) begin
                if (req_valid && exp_ready) begin
                    acc_evt = 1;
                    m_addr  = req_addr;
                    for (int w = 0; w <= int'(req_len); w++) begin
                        if (wide_bus) bq.push_back('{1'b1, req_dir, 1'b0, 1'b1, req_be});
                        else begin
                            bq.push_back('{1'b0, req_dir, 1'b0, 1'b0, req_be});
                            bq.push_back('{1'b0, req_dir, 1'b1, 1'b1, req_be});
                        end
                    end
                    phase = 1;
                end
            end else if (phase == 1) begin
                phase = 2;
            end else if (!ab_wait) begin
                b = bq.pop_front();
                if (!b.dir) begin
                    if (b.wide) begin exp_rv = 1; exp_rd = ab_dq_in; end
                    else if (!b.hi) m_lo = ab_dq_in[15:0];
                    else begin exp_rv = 1; exp_rd = {ab_dq_in[15:0], m_lo}; end
                end else if (b.eow) begin
                    void'(wq.pop_front());
                end
                if (bq.size() == 0) phase = 0;
            end
        end
    end

    // Issue one request; after acceptance scramble request inputs (R10).
    task automatic issue(input logic [31:0] a, input bit d, input logic [3:0] be,
                         input int len, input bit w);
        @(negedge clk);
        if (d) for (int i = 0; i <= len; i++) wq.push_back($urandom);
        req_addr  = a;
        req_dir   = d;
        req_be    = be;
        req_len   = len[LEN_W-1:0];
        wide_bus  = w;
        req_valid = 1'b1;
        do @(posedge clk); while (!acc_evt);
        @(negedge clk);
        req_valid = 1'b0;
        req_addr  = $urandom;
        req_dir   = $urandom;
        req_be    = $urandom;
        req_len   = $urandom;
        wide_bus  = $urandom;
    endtask

    task automatic drain();
        while (phase != 0 || bq.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    // Stimulus sequence.
    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R2: passive mode blocks acceptance, then active mode accepts
        passive_mode = 1'b1;
        fork
            issue(32'h1234_5678, 1'b1, 4'hF, 0, 1'b1);
            begin repeat (6) @(negedge clk); passive_mode = 1'b0; end
        join
        drain();
        // R7, R5: 32-bit write burst with waits
        wait_rand = 1; wait_pct = 40;
        issue(32'h0000_1000, 1'b1, 4'b1010, 3, 1'b1);
        drain();
        // R6, R3: 16-bit write burst, full-width address
        issue(32'hA5A5_C3C3, 1'b1, 4'b0110, 2, 1'b0);
        drain();
        // R8: 32-bit read, no waits
        wait_rand = 0;
        issue(32'hFFFF_0004, 1'b0, 4'hF, 2, 1'b1);
        drain();
        // R8, R5: 16-bit read with waits
        wait_rand = 1; wait_pct = 50;
        issue(32'h8000_0010, 1'b0, 4'b1001, 3, 1'b0);
        drain();
        // R4, R10: back-to-back mixed requests
        wait_pct = 25;
        issue(32'h0BAD_F00D, 1'b1, 4'b0011, 1, 1'b0);
        issue(32'h1357_9BDF, 1'b0, 4'b1100, 1, 1'b1);
        issue(32'h2468_ACE0, 1'b0, 4'b0101, 0, 1'b0);
        drain();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule